// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Selective Invalidation

This block caches translations for a 32-bit I/O virtual address space built from 4 KiB pages. Every cached translation belongs to one of 128 address spaces, named by a 7-bit identifier. A client presents an identifier and a virtual page number and gets back, in the same cycle, a hit flag, a 20-bit physical frame number and three permission bits. A page-table walker elsewhere writes new translations through the fill port after a miss.

Software removes stale translations with a 32-bit invalidation command. The command can match every entry, or only entries in one 4 MiB region, or only entries in one 16 KiB region. It can also be narrowed to a single address space. Neither lookups nor fills ever stall. A miss blocks nothing, so later lookups that hit are answered while the walker is still busy with the miss. The buffer is fully associative and has 32 entries by default.

Lookup, fill and invalidation are plain single-cycle strobes with no back-pressure. Each port is always accepted in the cycle its valid is high. The requester must therefore hold no expectation of a ready signal.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until a fill has been made.
- R2: A lookup with `lk_valid` high hits in the same cycle when a valid entry holds the same identifier and page number. On a hit, `lk_pfn` and `lk_perm` carry that entry's frame and permissions. On a miss, or with `lk_valid` low, `lk_hit`, `lk_pfn` and `lk_perm` are all zero.
- R3: A fill becomes visible to lookups from the cycle after it is presented. In `fill_perm`, bit 2 means readable, bit 1 means writable and bit 0 means non-secure.
- R4: A fill picks its slot in this order. First, a valid entry with the same identifier and page number, which is overwritten. Next, the lowest-numbered invalid entry. Otherwise, the slot named by a rotating pointer. The pointer is 0 after reset, advances by one each time it is used, and wraps after the last entry.
- R5: An invalidation with command bits [1:0] = 0 removes entries whatever their address.
- R6: With bits [1:0] = 2, only entries whose page-number bits [19:10] (address bits [31:22]) equal command bits [19:10] are removed.
- R7: With bits [1:0] = 3, only entries whose page-number bits [19:2] (address bits [31:14]) equal command bits [19:2] are removed.
- R8: A command with bits [1:0] = 1, or with any of bits [23:20] set, removes nothing.
- R9: When command bit 31 is set, an entry is removed only if its identifier equals command bits [30:24]. When bit 31 is clear, the identifier is not compared.
- R10: A lookup in the same cycle as an invalidation sees the state after the invalidation. A fill in the same cycle as an invalidation is applied after it, and entries removed in that cycle count as free for slot choice.
- R11: A miss changes no state and does not block the ports. A later lookup that hits still returns its translation while the missed page has not been filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_asid | input | 7 | Lookup address-space identifier |
| lk_vpn | input | 20 | Lookup virtual page number (address bits [31:12]) |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Physical frame number of the hit |
| lk_perm | output | 3 | Permissions of the hit: readable, writable, non-secure |
| fill_valid | input | 1 | Fill strobe |
| fill_asid | input | 7 | Identifier of the new translation |
| fill_vpn | input | 20 | Virtual page number of the new translation |
| fill_pfn | input | 20 | Physical frame number of the new translation |
| fill_perm | input | 3 | Permissions of the new translation |
| flush_valid | input | 1 | Invalidation strobe |
| flush_cmd | input | 32 | Invalidation command word |

## Verification
The assertions assume that the reset is held for at least one clock edge. They also assume that fills keep the buffer free of duplicates, which holds because the block itself routes a refill of an existing page to that page's slot; the stimulus never writes an entry any other way. The stimulus covers commands of all four modes, legal and illegal, with and without the identifier filter. It draws identifiers and page numbers from small pools, so section, group and exact matches are all frequent. It also places invalidations, fills and lookups in the same cycle, so the ordering rules of R10 are exercised.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int ASID_W   = 7;
  localparam int VA_W     = 32;
  localparam int PAGE_SH  = 12;
  localparam int SECT_SH  = 22;
  localparam int GROUP_SH = 14;
  localparam int VPN_W    = VA_W - PAGE_SH;
  localparam int PFN_W    = 20;
  localparam int PERM_W   = 3;
  localparam int CMD_W    = 32;
  localparam int SECT_W   = VA_W - SECT_SH;
  localparam int GROUP_W  = VA_W - GROUP_SH;
  localparam int SECT_LSB = SECT_SH - PAGE_SH;
  localparam int GROUP_LSB = GROUP_SH - PAGE_SH;
  localparam int RSV_LSB  = VPN_W;
  localparam int RSV_W    = CMD_W - 1 - ASID_W - VPN_W;

  typedef enum logic [1:0] {
    MATCH_ANY   = 2'd0,
    MATCH_NONE  = 2'd1,
    MATCH_SECT  = 2'd2,
    MATCH_GROUP = 2'd3
  } inv_mode_e;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
  } xlat_t;

  typedef struct packed {
    logic               en;
    logic               asid_chk;
    logic [ASID_W-1:0]  asid;
    inv_mode_e          mode;
    logic [SECT_W-1:0]  sect;
    logic [GROUP_W-1:0] group;
  } inv_req_t;
endpackage

// File: rtl/tlb_inv_decode.sv
module tlb_inv_decode
  import asid_tlb_pkg::*;
(
  input  logic             flush_valid,
  input  logic [CMD_W-1:0] flush_cmd,
  output inv_req_t         req
);
  logic              rsv_clear;
  inv_mode_e         mode;

  assign mode      = inv_mode_e'(flush_cmd[1:0]);
  assign rsv_clear = (flush_cmd[RSV_LSB +: RSV_W] == '0);

  always_comb begin
    req.en       = flush_valid && rsv_clear && (mode != MATCH_NONE);
    req.asid_chk = flush_cmd[CMD_W-1];
    req.asid     = flush_cmd[CMD_W-2 -: ASID_W];
    req.mode     = mode;
    req.sect     = flush_cmd[SECT_LSB +: SECT_W];
    req.group    = flush_cmd[GROUP_LSB +: GROUP_W];
  end
endmodule

// File: rtl/tlb_slot.sv
module tlb_slot
  import asid_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  inv_req_t          inv,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic              wr_en,
  input  xlat_t             wr_data,
  output logic              live,
  output logic              valid_q,
  output logic              lk_match,
  output logic              fill_match,
  output xlat_t             data
);
  xlat_t ent_q;
  logic  kill;
  logic  asid_ok;
  logic  addr_ok;

  assign asid_ok = !inv.asid_chk || (inv.asid == ent_q.asid);

  always_comb begin
    unique case (inv.mode)
      MATCH_ANY:   addr_ok = 1'b1;
      MATCH_SECT:  addr_ok = (inv.sect  == ent_q.vpn[VPN_W-1 -: SECT_W]);
      MATCH_GROUP: addr_ok = (inv.group == ent_q.vpn[VPN_W-1 -: GROUP_W]);
      default:     addr_ok = 1'b0;
    endcase
  end

  assign kill       = inv.en && valid_q && asid_ok && addr_ok;
  assign live       = valid_q && !kill;
  assign lk_match   = live && (ent_q.asid == lk_asid) && (ent_q.vpn == lk_vpn);
  assign fill_match = live && (ent_q.asid == fill_asid) && (ent_q.vpn == fill_vpn);
  assign data       = ent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ent_q   <= '0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      ent_q   <= wr_data;
    end else if (kill) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_valid,
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] dup,
  output logic [ENTRIES-1:0] wr_sel
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0]   rr_q;
  logic [ENTRIES-1:0] free;
  logic [ENTRIES-1:0] first_free;
  logic [ENTRIES-1:0] rr_hot;
  logic               use_rr;

  assign free       = ~live;
  assign first_free = free & (~free + ENTRIES'(1));
  assign rr_hot     = ENTRIES'(1) << rr_q;
  assign use_rr     = fill_valid && (dup == '0) && (free == '0);

  always_comb begin
    if (!fill_valid)        wr_sel = '0;
    else if (dup != '0)     wr_sel = dup;
    else if (free != '0)    wr_sel = first_free;
    else                    wr_sel = rr_hot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rr_q <= '0;
    else if (use_rr)  rr_q <= (rr_q == LAST) ? '0 : rr_q + PTR_W'(1);
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush_valid,
  input  logic [CMD_W-1:0]  flush_cmd
);
  inv_req_t           inv;
  xlat_t              wr_data;
  xlat_t              slot_data [ENTRIES];
  logic [ENTRIES-1:0] live;
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] dup;
  logic [ENTRIES-1:0] wr_sel;

  tlb_inv_decode u_dec (
    .flush_valid (flush_valid),
    .flush_cmd   (flush_cmd),
    .req         (inv)
  );

  assign wr_data = '{asid: fill_asid, vpn: fill_vpn, pfn: fill_pfn, perm: fill_perm};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    tlb_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .inv        (inv),
      .lk_asid    (lk_asid),
      .lk_vpn     (lk_vpn),
      .fill_asid  (fill_asid),
      .fill_vpn   (fill_vpn),
      .wr_en      (wr_sel[i]),
      .wr_data    (wr_data),
      .live       (live[i]),
      .valid_q    (valid_q[i]),
      .lk_match   (lk_match[i]),
      .fill_match (dup[i]),
      .data       (slot_data[i])
    );
  end

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_valid (fill_valid),
    .live       (live),
    .dup        (dup),
    .wr_sel     (wr_sel)
  );

  always_comb begin
    lk_hit  = 1'b0;
    lk_pfn  = '0;
    lk_perm = '0;
    if (lk_valid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (lk_match[i]) begin
          lk_hit  = 1'b1;
          lk_pfn  = lk_pfn  | slot_data[i].pfn;
          lk_perm = lk_perm | slot_data[i].perm;
        end
      end
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic               fill_valid,
  input logic               flush_valid,
  input logic [31:0]        flush_cmd,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] wr_sel
);
  // R2: no hit without a lookup
  p_hit_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);

  // R1: buffer empty in the first cycle after reset
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (valid_q == '0));

  // R3: a fill always leaves at least one valid entry
  p_fill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (valid_q != '0));

  // R4: at most one slot written per fill
  p_one_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  // R5: unfiltered match-any command with no fill empties the buffer
  p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !fill_valid && flush_cmd[31] == 1'b0 &&
     flush_cmd[1:0] == 2'd0 && flush_cmd[23:20] == 4'd0) |=> (valid_q == '0));

  // R11: without fill or invalidation the contents hold
  p_quiet_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_valid && !flush_valid) |=> $stable(valid_q));
endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_hit      (lk_hit),
  .fill_valid  (fill_valid),
  .flush_valid (flush_valid),
  .flush_cmd   (flush_cmd),
  .valid_q     (valid_q),
  .wr_sel      (wr_sel)
);

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [6:0]  lk_asid = '0;
  logic [19:0] lk_vpn = '0;
  logic        lk_hit;
  logic [19:0] lk_pfn;
  logic [2:0]  lk_perm;
  logic        fill_valid = 1'b0;
  logic [6:0]  fill_asid = '0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        flush_valid = 1'b0;
  logic [31:0] flush_cmd = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  bit          m_v    [N];
  logic [6:0]  m_asid [N];
  logic [19:0] m_vpn  [N];
  logic [19:0] m_pfn  [N];
  logic [2:0]  m_perm [N];
  int          m_rr = 0;

  always #4 clk = ~clk;

  asid_tlb #(.ENTRIES(N)) uut (.*);

  function automatic bit inv_hits(int i, logic [31:0] c);
    bit ok;
    if (c[1:0] == 2'd1 || c[23:20] != 4'd0) return 0;
    if (c[31] && c[30:24] != m_asid[i]) return 0;
    case (c[1:0])
      2'd0: ok = 1;
      2'd2: ok = (c[19:10] == m_vpn[i][19:10]);
      default: ok = (c[19:2] == m_vpn[i][19:2]);
    endcase
    return ok;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit          live [N];
      bit          e_hit;
      logic [19:0] e_pfn;
      logic [2:0]  e_perm;
      int          slot;
      cycles++;
      for (int i = 0; i < N; i++)
        live[i] = m_v[i] && !(flush_valid && inv_hits(i, flush_cmd));
      e_hit = 0; e_pfn = '0; e_perm = '0;
      if (lk_valid)
        for (int i = 0; i < N; i++)
          if (live[i] && m_asid[i] == lk_asid && m_vpn[i] == lk_vpn) begin
            e_hit = 1; e_pfn = m_pfn[i]; e_perm = m_perm[i];
          end
      checks++;
      if (lk_hit !== e_hit || lk_pfn !== e_pfn || lk_perm !== e_perm) begin
        errors++;
        $display("FAIL %s: hit=%0b pfn=%h perm=%b expected hit=%0b pfn=%h perm=%b",
                 tag, lk_hit, lk_pfn, lk_perm, e_hit, e_pfn, e_perm);
      end
      for (int i = 0; i < N; i++) m_v[i] = live[i];
      if (fill_valid) begin
        slot = -1;
        for (int i = 0; i < N; i++)
          if (slot < 0 && m_v[i] && m_asid[i] == fill_asid && m_vpn[i] == fill_vpn) slot = i;
        for (int i = 0; i < N; i++)
          if (slot < 0 && !m_v[i]) slot = i;
        if (slot < 0) begin
          slot = m_rr;
          m_rr = (m_rr + 1) % N;
        end
        m_v[slot] = 1; m_asid[slot] = fill_asid; m_vpn[slot] = fill_vpn;
        m_pfn[slot] = fill_pfn; m_perm[slot] = fill_perm;
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    lk_valid = 0; fill_valid = 0; flush_valid = 0;
  endtask

  task automatic look(input logic [6:0] a, input logic [19:0] v);
    lk_valid = 1; lk_asid = a; lk_vpn = v; tick();
  endtask

  task automatic set_fill(input logic [6:0] a, input logic [19:0] v,
                          input logic [19:0] p, input logic [2:0] pm);
    fill_valid = 1; fill_asid = a; fill_vpn = v; fill_pfn = p; fill_perm = pm;
  endtask

  task automatic set_flush(input logic [31:0] c);
    flush_valid = 1; flush_cmd = c;
  endtask

  function automatic logic [31:0] sect_cmd(bit en, logic [6:0] a, logic [19:0] v);
    return {en, a, 4'd0, v[19:10], 8'd0, 2'd2};
  endfunction

  function automatic logic [31:0] grp_cmd(bit en, logic [6:0] a, logic [19:0] v);
    return {en, a, 4'd0, v[19:2], 2'd3};
  endfunction

  task automatic fill_grid();
    for (int i = 0; i < 8; i++) begin
      set_fill(7'(i % 2), 20'(i << 2) | 20'((i / 4) << 10), 20'(100 + i), 3'(i)); tick();
    end
  endtask

  task automatic probe_grid();
    for (int i = 0; i < 8; i++) look(7'(i % 2), 20'(i << 2) | 20'((i / 4) << 10));
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_asid[i] = '0; m_vpn[i] = '0; m_pfn[i] = '0; m_perm[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    tag = "R1"; look(7'd0, 20'd0); look(7'd5, 20'h12345);

    tag = "R3"; set_fill(7'd3, 20'h00AB0, 20'hCAFE1, 3'b101); look(7'd3, 20'h00AB0);
    tag = "R2"; look(7'd3, 20'h00AB0); look(7'd4, 20'h00AB0); look(7'd3, 20'h00AB1);
    lk_valid = 0; tick();

    tag = "R4"; set_fill(7'd3, 20'h00AB0, 20'h0BEEF, 3'b110); tick(); look(7'd3, 20'h00AB0);
    tag = "R5"; set_flush(32'h0); tick(); look(7'd3, 20'h00AB0);

    tag = "R4";
    for (int i = 0; i < N + 3; i++) begin
      set_fill(7'd9, 20'(i), 20'(i + 500), 3'b111); tick();
    end
    for (int i = 0; i < N + 3; i++) look(7'd9, 20'(i));

    tag = "R9"; set_flush({1'b1, 7'd1, 24'd0}); tick();
    fill_grid(); set_flush({1'b1, 7'd1, 24'd0}); tick(); probe_grid();
    tag = "R5"; set_flush({1'b0, 7'd1, 24'd0}); tick(); probe_grid();
    tag = "R6"; fill_grid(); set_flush(sect_cmd(0, 0, 20'h00400)); tick(); probe_grid();
    tag = "R7"; fill_grid(); set_flush(grp_cmd(0, 0, 20'h00008)); tick(); probe_grid();
    tag = "R9"; set_flush(grp_cmd(1, 7'd1, 20'h0000C)); tick(); probe_grid();
    tag = "R8"; fill_grid(); set_flush(32'h0000_0001); tick(); probe_grid();
    set_flush(32'h0010_0000); tick(); probe_grid();

    tag = "R10"; set_flush(32'h0); lk_valid = 1; lk_asid = 0; lk_vpn = 0; tick();
    fill_grid(); set_flush(32'h0); set_fill(7'd2, 20'h7, 20'h77, 3'b010); tick();
    look(7'd2, 20'h7); probe_grid();

    tag = "R11"; look(7'd2, 20'h8); look(7'd2, 20'h7); look(7'd6, 20'h1); look(7'd2, 20'h7);

    tag = "R2";
    for (int k = 0; k < 4000; k++) begin
      logic [19:0] v;
      v = {9'd0, 1'($urandom % 2), 6'd0, 2'($urandom % 4), 2'($urandom % 4)};
      lk_valid = ($urandom % 4) != 0;
      lk_asid = 7'($urandom % 3);
      lk_vpn = v;
      if ($urandom % 3 == 0)
        set_fill(7'($urandom % 3), {9'd0, 1'($urandom % 2), 6'd0, 2'($urandom % 4), 2'($urandom % 4)},
                 20'($urandom), 3'($urandom));
      if ($urandom % 10 == 0) begin
        case ($urandom % 4)
          0: set_flush({1'($urandom % 2), 7'($urandom % 3), 22'd0, 2'($urandom % 2)});
          1: set_flush(sect_cmd(1'($urandom % 2), 7'($urandom % 3), v));
          2: set_flush(grp_cmd(1'($urandom % 2), 7'($urandom % 3), v));
          default: set_flush(32'h0010_0003);
        endcase
      end
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule